// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block is the sending half of a byte-wide monitor channel carried in a time-division serial frame. Each frame, it presents one byte in the monitor slot along with an active-low transmit flag (`mx_out`). Once per frame, it also samples the partner's active-low acknowledge flag (`mr_in`). All protocol timing follows a single-cycle `frame_strobe`. On the strobe cycle the block samples `mr_in` and moves its flag and slot byte to their values for the next frame.

Software loads each byte into a holding register with `cpu_wr`. The block waits until the channel has been quiet for a set number of frames, then opens the message. It raises `irq_txba` each time the partner acknowledges a byte. A byte written while the previous one is still unacknowledged is announced only after that acknowledge, by releasing the flag for exactly one frame. After the last acknowledge, software pulses `eom_req`, and the block holds the flag inactive for the end-of-message frames.

If the partner keeps its acknowledge flag inactive for too many frames in the middle of a message, the block treats this as an abort. It then closes the message and pulses `irq_abort`.

Top module: `mon_hs_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `mx_out` is 1, `mon_tx_byte` is 8'hFF, and both interrupt outputs are 0.
- R2: From idle, a message starts only at a strobe where `mr_in` is 1 and the strobe before it also saw `mr_in` 1 (at least 2 consecutive frames). A strobe with `mr_in` 0 restarts this count.
- R3: At the starting strobe, provided a byte is held, `mx_out` becomes 0 and `mon_tx_byte` carries that byte. Whenever `mx_out` is 1, `mon_tx_byte` is 8'hFF.
- R4: While a byte is awaiting acknowledge, a strobe that samples `mr_in` 0 after the previous strobe sampled 1 is an acknowledge. `irq_txba` is then high for exactly the one cycle after that strobe, and `mx_out` stays 0.
- R5: A byte written while the current byte is still unacknowledged does not change `mon_tx_byte` until after the acknowledge.
- R6: If a byte is held once the current one is acknowledged, the next strobe drives `mx_out` to 1 for one frame. The strobe after that drives it back to 0 with the new byte in the slot.
- R7: `mr_in` staying 0 across strobes is not an acknowledge and raises no interrupt.
- R8: `eom_req` is remembered. Once the last byte is acknowledged and no byte is held, the next strobe sets `mx_out` to 1 for 2 frames, and the block returns to idle. A new message then needs a fresh idle count.
- R9: After the first acknowledge of a message, `mr_in` sampled 1 at 2 consecutive strobes is an abort. `irq_abort` then pulses for one cycle, and `mx_out` goes to 1 for the end-of-message frames. A single frame of `mr_in` 1 is not an abort.
- R10: `mx_out` changes only in the cycle right after a strobe.
- R11: An `eom_req` pulse while the block is idle has no effect on the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse per frame |
| mr_in | input | 1 | Partner acknowledge flag, active low |
| cpu_wr | input | 1 | Holding register write strobe |
| cpu_data | input | 8 | Byte to write |
| eom_req | input | 1 | End-of-message request pulse |
| mx_out | output | 1 | Transmit flag, active low |
| mon_tx_byte | output | 8 | Monitor slot byte |
| irq_txba | output | 1 | Byte acknowledged, one-cycle pulse |
| irq_abort | output | 1 | Abort detected, one-cycle pulse |

## Verification
Every cycle, the bound checker verifies four things. The flag moves only after a strobe. The slot reads all ones while the flag is inactive. Each acknowledge or abort event produces its single-cycle interrupt with the flag at the matching level. A start occurs only on a quiet acknowledge line. The bench scenarios are what show the frame-counted sequences: the two-frame idle gate and its restart, the one-frame gap before a held byte, the two end-of-message frames with the re-arming of the idle count, and the difference between a one-frame acknowledge pulse and a two-frame abort.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_GAP  = 3'd3,
    ST_END  = 3'd4
  } mon_st_e;

  // acknowledge: flag seen inactive last frame, active this frame
  function automatic logic mr_ack(input logic mr_now, input logic mr_before);
    return (!mr_now) && mr_before;
  endfunction

  // frames on which abort watching applies
  function automatic logic in_transfer(input mon_st_e st);
    return (st == ST_SEND) || (st == ST_WAIT) || (st == ST_GAP);
  endfunction
endpackage

// File: rtl/mon_hs_frmcnt.sv
module mon_hs_frmcnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic inc_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i && inc_i && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = step_i && inc_i && !clr_i && (cnt_q >= CW'(LIMIT - 1));
endmodule

// File: rtl/mon_hs_hold.sv
module mon_hs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] q_o,
  output logic              v_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
      v_o <= 1'b0;
    end else if (wr_i) begin
      q_o <= data_i;
      v_o <= 1'b1;
    end else if (take_i) begin
      v_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_hs_fsm.sv
module mon_hs_fsm
  import mon_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              mr_i,
  input  logic              eom_req_i,
  input  logic              hold_v_i,
  input  logic [DATA_W-1:0] hold_q_i,
  input  logic              idle_hit_i,
  input  logic              abort_hit_i,
  input  logic              end_hit_i,
  output mon_st_e           st_o,
  output logic              acked_o,
  output logic              take_o,
  output logic              ev_start_o,
  output logic              ev_ack_o,
  output logic              ev_abort_o,
  output logic              mx_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              irq_txba_o,
  output logic              irq_abort_o
);
  mon_st_e           st_q;
  logic              mx_q;
  logic [DATA_W-1:0] cur_q;
  logic              mr_prev_q;
  logic              acked_q;
  logic              eom_q;
  logic              txba_q;
  logic              abrt_q;

  logic ev_gap, ev_end, ev_next;

  always_comb begin
    ev_start_o = step_i && (st_q == ST_IDLE) && idle_hit_i && hold_v_i;
    ev_ack_o   = step_i && (st_q == ST_SEND) && mr_ack(mr_i, mr_prev_q);
    ev_abort_o = abort_hit_i;
    ev_gap     = step_i && (st_q == ST_WAIT) && !abort_hit_i && hold_v_i;
    ev_end     = step_i && (st_q == ST_WAIT) && !abort_hit_i && !hold_v_i && eom_q;
    ev_next    = step_i && (st_q == ST_GAP) && !abort_hit_i;
    take_o     = ev_start_o || ev_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mx_q      <= 1'b1;
      cur_q     <= '0;
      mr_prev_q <= 1'b1;
      acked_q   <= 1'b0;
      eom_q     <= 1'b0;
      txba_q    <= 1'b0;
      abrt_q    <= 1'b0;
    end else begin
      txba_q <= ev_ack_o;
      abrt_q <= ev_abort_o;
      if (step_i) mr_prev_q <= mr_i;

      if (end_hit_i)                        eom_q <= 1'b0;
      else if (eom_req_i && st_q != ST_IDLE) eom_q <= 1'b1;

      if (ev_abort_o) begin
        st_q <= ST_END;
        mx_q <= 1'b1;
      end else if (ev_start_o || ev_next) begin
        st_q  <= ST_SEND;
        mx_q  <= 1'b0;
        cur_q <= hold_q_i;
        if (ev_start_o) acked_q <= 1'b0;
      end else if (ev_ack_o) begin
        st_q    <= ST_WAIT;
        acked_q <= 1'b1;
      end else if (ev_gap) begin
        st_q <= ST_GAP;
        mx_q <= 1'b1;
      end else if (ev_end) begin
        st_q <= ST_END;
        mx_q <= 1'b1;
      end else if (end_hit_i) begin
        st_q    <= ST_IDLE;
        acked_q <= 1'b0;
      end
    end
  end

  assign st_o        = st_q;
  assign acked_o     = acked_q;
  assign mx_o        = mx_q;
  assign byte_o      = mx_q ? {DATA_W{1'b1}} : cur_q;
  assign irq_txba_o  = txba_q;
  assign irq_abort_o = abrt_q;
endmodule

// File: rtl/mon_hs_tx.sv
module mon_hs_tx
  import mon_hs_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int IDLE_FRAMES  = 2,
  parameter int END_FRAMES   = 2,
  parameter int ABORT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic              mr_in,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              eom_req,
  output logic              mx_out,
  output logic [DATA_W-1:0] mon_tx_byte,
  output logic              irq_txba,
  output logic              irq_abort
);
  mon_st_e           st;
  logic              acked;
  logic              take;
  logic              hold_v;
  logic [DATA_W-1:0] hold_q;
  logic              idle_hit, abort_hit, end_hit;
  logic              idle_clr, abort_clr, end_clr, abort_inc;
  logic              ev_start, ev_ack, ev_abort;

  always_comb begin
    idle_clr  = (st != ST_IDLE) || (frame_strobe && !mr_in);
    abort_inc = in_transfer(st) && acked;
    abort_clr = !abort_inc || (frame_strobe && !mr_in);
    end_clr   = (st != ST_END);
  end

  mon_hs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_i(cpu_wr), .data_i(cpu_data),
    .take_i(take), .q_o(hold_q), .v_o(hold_v)
  );

  mon_hs_frmcnt #(.LIMIT(IDLE_FRAMES)) u_idle_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(frame_strobe), .inc_i(mr_in),
    .clr_i(idle_clr), .hit_o(idle_hit)
  );

  mon_hs_frmcnt #(.LIMIT(ABORT_FRAMES)) u_abort_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(frame_strobe), .inc_i(abort_inc && mr_in),
    .clr_i(abort_clr), .hit_o(abort_hit)
  );

  mon_hs_frmcnt #(.LIMIT(END_FRAMES)) u_end_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(frame_strobe), .inc_i(1'b1),
    .clr_i(end_clr), .hit_o(end_hit)
  );

  mon_hs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .step_i(frame_strobe), .mr_i(mr_in),
    .eom_req_i(eom_req), .hold_v_i(hold_v), .hold_q_i(hold_q),
    .idle_hit_i(idle_hit), .abort_hit_i(abort_hit), .end_hit_i(end_hit),
    .st_o(st), .acked_o(acked), .take_o(take),
    .ev_start_o(ev_start), .ev_ack_o(ev_ack), .ev_abort_o(ev_abort),
    .mx_o(mx_out), .byte_o(mon_tx_byte),
    .irq_txba_o(irq_txba), .irq_abort_o(irq_abort)
  );
endmodule

// File: rtl/mon_hs_tx_chk.sv
module mon_hs_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_strobe,
  input logic              mr_in,
  input logic              mx_out,
  input logic [DATA_W-1:0] mon_tx_byte,
  input logic              irq_txba,
  input logic              irq_abort,
  input logic              ev_start,
  input logic              ev_ack,
  input logic              ev_abort
);
  // R10
  mx_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_strobe) |-> $stable(mx_out));

  // R3
  slot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mx_out |-> (mon_tx_byte == {DATA_W{1'b1}}));

  // R4
  txba_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txba |=> !irq_txba);

  // R4
  ack_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (irq_txba && !mx_out));

  // R9
  abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (irq_abort && mx_out));

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |=> !irq_abort);

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (mr_in && mx_out));
endmodule

bind mon_hs_tx mon_hs_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .mr_in(mr_in),
  .mx_out(mx_out), .mon_tx_byte(mon_tx_byte), .irq_txba(irq_txba),
  .irq_abort(irq_abort), .ev_start(ev_start), .ev_ack(ev_ack),
  .ev_abort(ev_abort)
);

// File: tb/mon_hs_tx_tb.sv
module mon_hs_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic       mr_in = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_data = 8'h00;
  logic       eom_req = 1'b0;
  logic       mx_out;
  logic [7:0] mon_tx_byte;
  logic       irq_txba;
  logic       irq_abort;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mon_hs_tx u_dut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .mr_in(mr_in),
    .cpu_wr(cpu_wr), .cpu_data(cpu_data), .eom_req(eom_req),
    .mx_out(mx_out), .mon_tx_byte(mon_tx_byte),
    .irq_txba(irq_txba), .irq_abort(irq_abort)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one frame: strobe with given mr, return at the negedge after the strobe edge
  task automatic frame(input logic mr);
    @(negedge clk);
    mr_in = mr;
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1;
    cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic pulse_eom();
    @(negedge clk);
    eom_req = 1'b1;
    @(negedge clk);
    eom_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 mx", mx_out, 1'b1);
    check("R1 byte", mon_tx_byte, 8'hFF);
    check("R1 irqs", {irq_txba, irq_abort}, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mx after release", mx_out, 1'b1);
  endtask

  task automatic t_idle_gate();
    pulse_eom();                     // R11: ignored while idle
    cpu_write(8'hA5);
    frame(1'b0); check("R2 busy line", mx_out, 1'b1);
    frame(1'b1); check("R2 one quiet frame", mx_out, 1'b1);
    frame(1'b0); check("R2 count restart", mx_out, 1'b1);
    frame(1'b1); check("R2 one quiet again", mx_out, 1'b1);
    frame(1'b1); check("R3 start mx", mx_out, 1'b0);
    check("R3 start byte", mon_tx_byte, 8'hA5);
  endtask

  task automatic t_first_ack();
    frame(1'b0);
    check("R4 irq_txba", irq_txba, 1'b1);
    check("R4 mx held", mx_out, 1'b0);
    @(negedge clk);
    check("R4 single pulse", irq_txba, 1'b0);
    frame(1'b0);
    check("R11 no eom from idle request", mx_out, 1'b0);
    check("R7 no irq on steady mr", irq_txba, 1'b0);
  endtask

  task automatic t_next_byte();
    cpu_write(8'h3C);
    frame(1'b0); check("R6 gap mx", mx_out, 1'b1);
    check("R3 gap byte", mon_tx_byte, 8'hFF);
    frame(1'b0); check("R6 resume mx", mx_out, 1'b0);
    check("R6 new byte", mon_tx_byte, 8'h3C);
  endtask

  task automatic t_held_write();
    cpu_write(8'h77);
    check("R5 byte unchanged", mon_tx_byte, 8'h3C);
    frame(1'b0);
    check("R7 steady mr no ack", irq_txba, 1'b0);
    check("R5 still 3C", mon_tx_byte, 8'h3C);
    frame(1'b1);
    check("R9 one quiet frame no abort", irq_abort, 1'b0);
    check("R5 mx still active", mx_out, 1'b0);
    frame(1'b0);
    check("R4 second ack", irq_txba, 1'b1);
    frame(1'b0); check("R6 gap before 77", mx_out, 1'b1);
    frame(1'b0); check("R5 held byte sent", mon_tx_byte, 8'h77);
    frame(1'b1);
    frame(1'b0); check("R4 third ack", irq_txba, 1'b1);
  endtask

  task automatic t_eom();
    pulse_eom();
    frame(1'b0); check("R8 end frame 1", mx_out, 1'b1);
    cpu_write(8'h11);
    frame(1'b0); check("R8 end frame 2", mx_out, 1'b1);
    frame(1'b0); check("R8 back to idle", mx_out, 1'b1);
    frame(1'b1); check("R8 idle recount", mx_out, 1'b1);
    frame(1'b1); check("R8 restart", mx_out, 1'b0);
    check("R8 restart byte", mon_tx_byte, 8'h11);
  endtask

  task automatic t_abort();
    frame(1'b0); check("R4 ack before abort", irq_txba, 1'b1);
    frame(1'b1); check("R9 first quiet frame", irq_abort, 1'b0);
    check("R9 mx still active", mx_out, 1'b0);
    frame(1'b1);
    check("R9 irq_abort", irq_abort, 1'b1);
    check("R9 mx released", mx_out, 1'b1);
    check("R9 no txba", irq_txba, 1'b0);
    @(negedge clk);
    check("R9 single pulse", irq_abort, 1'b0);
    frame(1'b1); check("R9 end frame", mx_out, 1'b1);
    frame(1'b1); check("R9 idle", mx_out, 1'b1);
    cpu_write(8'h22);
    frame(1'b1); check("R2 after abort wait", mx_out, 1'b1);
    frame(1'b1); check("R3 after abort start", mon_tx_byte, 8'h22);
  endtask

  initial begin
    t_reset();
    t_idle_gate();
    t_first_ack();
    t_next_byte();
    t_held_write();
    t_eom();
    t_abort();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule